// File: doc/BRIEF.md
# Grouped Interrupt Expansion Controller

This block gathers up to 96 peripheral interrupt request lines and folds them into 12 CPU interrupt outputs. The sources are split into 12 groups of 8. A rising request on a source sets that source's sticky flag. Each source has its own enable bit. A group's CPU output is raised while the group holds at least one flagged and enabled source and its acknowledge gate is open.

When the CPU services one of its interrupt lines, the block picks the winning source in that group. The winner is the pending, enabled source with the lowest number. At the edge where the service request is accepted, the block clears the winner's flag and closes the group's acknowledge gate. Eight cycles after that edge, the block presents the winner's 32-bit vector with a one-cycle valid strobe. The vector comes from a writable table with one entry per source.

Software drives a small write-only register bus. Through it, software programs the vectors, writes the enable byte of each group and reopens acknowledge gates with write-one-to-clear.

The fetch sequencer is a three-state machine:
- FS_IDLE moves to FS_WAIT on an accepted service request (the accept transition).
- FS_WAIT counts down and moves to FS_DELIVER when its counter reaches zero (the expire transition).
- FS_DELIVER always returns to FS_IDLE after one cycle (the release transition).

Top module: `irq_fold_ctrl`

## Requirements
- R1: A source flag is set only by a low-to-high change of its request input. A request held high after its flag was fetched does not set the flag again until the input falls and rises once more.
- R2: `cpu_irq[g]` (bit g drives CPU line g+1, g = 0..11) is high exactly when some source g*8+b (b = 0..7) is both flagged and enabled and the acknowledge bit of group g is clear. Several groups can be high at once.
- R3: A disabled source never raises its group output, but its flag still latches. Enabling the source later raises the output in the cycle after the enable write, with no new request edge.
- R4: `vec_valid` is high for exactly one cycle. It rises 8 clock edges after the edge that accepted `svc_req`. While it is high, `vec_data` carries the vector. At all other times `vec_data` is zero.
- R5: The returned vector belongs to the lowest-numbered source in the serviced group that is both flagged and enabled. Flagged but disabled sources are skipped.
- R6: At the edge that accepts a service request with a winner, the winner's flag is cleared and the group's acknowledge bit is set. The group output is low from the next cycle on, until software clears the acknowledge bit.
- R7: A bus write with `bus_addr[8:7]`=2 clears the acknowledge bit of every group g whose `bus_wdata[g]` is 1. Bits written as 0 leave their acknowledge bits unchanged.
- R8: A bus write with `bus_addr[8:7]`=0 stores `bus_wdata` as the vector of source `bus_addr[6:0]` (group*8+bit). The table is read when the vector is delivered, so an overwrite during a fetch in flight is the value returned.
- R9: If a source's request rises in the same cycle that a fetch clears its flag, the flag stays set.
- R10: A `svc_req` that arrives while a fetch is in flight is ignored. It produces no vector strobe and clears no flag.
- R11: Servicing a line whose group has no flagged and enabled source, or a line number of 12 or more, still yields a strobe after 8 cycles, with `vec_data` zero. No acknowledge bit is set in that case.
- R12: A bus write with `bus_addr[8:7]`=1 loads `bus_wdata[7:0]` as the enable bits of group `bus_addr[3:0]`, with bit b enabling source group*8+b. Reset clears all flags, enables, acknowledge bits and vectors, and holds `cpu_irq`, `vec_valid` and `vec_data` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 96 | Peripheral request lines, source n at bit n |
| cpu_irq | output | 12 | Grouped CPU interrupt outputs, bit g drives CPU line g+1 |
| svc_req | input | 1 | CPU service request, sampled in FS_IDLE |
| svc_line | input | 4 | Zero-based CPU line being serviced |
| vec_valid | output | 1 | One-cycle strobe marking the delivered vector |
| vec_data | output | 32 | Delivered vector, zero when not valid |
| bus_we | input | 1 | Register bus write strobe |
| bus_addr | input | 9 | Region in bits 8:7, index in bits 6:0 |
| bus_wdata | input | 32 | Register bus write data |

## Verification
A request edge shows on `cpu_irq` one edge after it is driven. An enable write or an acknowledge-clear write shows one edge after its strobe. An accepted service request drops its group output one edge later and strobes the vector eight edges after the accept edge. The bench drives every input on the falling clock edge and samples outputs on the following falling edge, at which point each of these results is due. The service driver stores the expected vector together with the cycle number in which it must appear. A monitor then compares both the value and the cycle of every strobe, and reports a strobe that nobody requested.

// File: rtl/irq_fold_pkg.sv
package irq_fold_pkg;

    // Fetch sequencer states
    typedef enum logic [1:0] {
        FS_IDLE    = 2'd0,
        FS_WAIT    = 2'd1,
        FS_DELIVER = 2'd2
    } fetch_state_t;

    // Register bus regions, decoded from the two top address bits
    localparam logic [1:0] RGN_VEC = 2'd0;
    localparam logic [1:0] RGN_EN  = 2'd1;
    localparam logic [1:0] RGN_ACK = 2'd2;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NSRC  = 96,
    parameter int IDX_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_src,
    input  logic            clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [NSRC-1:0] flags
);

    logic [NSRC-1:0] prev_q;
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] clr_mask;

    assign rise     = irq_src & ~prev_q;
    assign clr_mask = clr_en ? (NSRC'(1) << clr_idx) : '0;

    // A new edge outranks the fetch clear on the same source
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            flag_q <= '0;
        end else begin
            prev_q <= irq_src;
            flag_q <= (flag_q & ~clr_mask) | rise;
        end
    end

    assign flags = flag_q;

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_fold_pkg::*;
#(
    parameter int NUM_GROUPS = 12,
    parameter int GROUP_SIZE = 8,
    parameter int GRP_W      = 4,
    localparam int NSRC      = NUM_GROUPS * GROUP_SIZE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [1:0]            bus_rgn,
    input  logic [GRP_W-1:0]      bus_grp,
    input  logic [GROUP_SIZE-1:0] en_wdata,
    input  logic [NUM_GROUPS-1:0] ack_wdata,
    input  logic                  ack_set,
    input  logic [GRP_W-1:0]      ack_set_grp,
    output logic [NSRC-1:0]       enables,
    output logic [NUM_GROUPS-1:0] ack
);

    logic en_wr;
    logic ack_wr;

    assign en_wr  = bus_we && (bus_rgn == RGN_EN);
    assign ack_wr = bus_we && (bus_rgn == RGN_ACK);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic [GROUP_SIZE-1:0] en_q;
        logic                  ack_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q <= '0;
            end else if (en_wr && (int'(bus_grp) == g)) begin
                en_q <= en_wdata;
            end
        end

        // Fetch-side set outranks a software clear in the same cycle
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ack_q <= 1'b0;
            end else if (ack_set && (int'(ack_set_grp) == g)) begin
                ack_q <= 1'b1;
            end else if (ack_wr && ack_wdata[g]) begin
                ack_q <= 1'b0;
            end
        end

        assign enables[g*GROUP_SIZE +: GROUP_SIZE] = en_q;
        assign ack[g]                              = ack_q;
    end

endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
    parameter int NSRC  = 96,
    parameter int VEC_W = 32,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VEC_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VEC_W-1:0] rd_data
);

    logic [VEC_W-1:0] mem_q [NSRC];

    for (genvar i = 0; i < NSRC; i++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else if (wr_en && (int'(wr_idx) == i)) begin
                mem_q[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_idx) < NSRC) begin
            rd_data = mem_q[rd_idx];
        end
    end

endmodule

// File: rtl/irq_group_arb.sv
module irq_group_arb #(
    parameter int NUM_GROUPS = 12,
    parameter int GROUP_SIZE = 8,
    parameter int GRP_W      = 4,
    parameter int IDX_W      = 7,
    localparam int NSRC      = NUM_GROUPS * GROUP_SIZE,
    localparam int BIT_W     = $clog2(GROUP_SIZE)
) (
    input  logic [NSRC-1:0]       pend,
    input  logic [GRP_W-1:0]      sel_grp,
    output logic [NUM_GROUPS-1:0] grp_any,
    output logic                  hit,
    output logic [IDX_W-1:0]      win_idx
);

    logic [NUM_GROUPS*BIT_W-1:0] low_all;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_enc
        logic [GROUP_SIZE-1:0] gp;
        logic [BIT_W-1:0]      low;

        assign gp = pend[g*GROUP_SIZE +: GROUP_SIZE];

        // Scan downward so the lowest set bit is the last one written
        always_comb begin
            low = '0;
            for (int b = GROUP_SIZE - 1; b >= 0; b--) begin
                if (gp[b]) begin
                    low = BIT_W'(b);
                end
            end
        end

        assign grp_any[g]                   = |gp;
        assign low_all[g*BIT_W +: BIT_W]    = low;
    end

    always_comb begin
        hit     = 1'b0;
        win_idx = '0;
        if (int'(sel_grp) < NUM_GROUPS) begin
            hit     = grp_any[sel_grp];
            win_idx = IDX_W'(int'(sel_grp) * GROUP_SIZE
                             + int'(low_all[sel_grp*BIT_W +: BIT_W]));
        end
    end

endmodule

// File: rtl/irq_fetch_fsm.sv
module irq_fetch_fsm
    import irq_fold_pkg::*;
#(
    parameter int FETCH_CYCLES = 8,
    parameter int IDX_W        = 7,
    localparam int CNT_W       = $clog2(FETCH_CYCLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             svc_req,
    input  logic             hit,
    input  logic [IDX_W-1:0] win_idx,
    output logic             take_hit,
    output logic             vec_valid,
    output logic             lat_hit,
    output logic [IDX_W-1:0] lat_idx
);

    fetch_state_t state_q;
    fetch_state_t state_d;
    logic [CNT_W-1:0] cnt_q;
    logic accept;

    assign accept = (state_q == FS_IDLE) && svc_req;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:    if (svc_req) state_d = FS_WAIT;
            FS_WAIT:    if (cnt_q == '0) state_d = FS_DELIVER;
            FS_DELIVER: state_d = FS_IDLE;
            default:    state_d = FS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Wait counter: FS_WAIT lasts FETCH_CYCLES-1 edges after accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= CNT_W'(FETCH_CYCLES - 1);
        end else if (state_q == FS_WAIT && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Winner latched on the accept edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_hit <= 1'b0;
            lat_idx <= '0;
        end else if (accept) begin
            lat_hit <= hit;
            lat_idx <= win_idx;
        end
    end

    // Outputs
    always_comb begin
        take_hit  = 1'b0;
        vec_valid = 1'b0;
        unique case (state_q)
            FS_IDLE:    take_hit  = svc_req && hit;
            FS_WAIT:    vec_valid = 1'b0;
            FS_DELIVER: vec_valid = 1'b1;
            default:    vec_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_fold_ctrl.sv
module irq_fold_ctrl
    import irq_fold_pkg::*;
#(
    parameter int NUM_GROUPS   = 12,
    parameter int GROUP_SIZE   = 8,
    parameter int VEC_W        = 32,
    parameter int FETCH_CYCLES = 8,
    localparam int NSRC        = NUM_GROUPS * GROUP_SIZE,
    localparam int IDX_W       = $clog2(NSRC),
    localparam int GRP_W       = $clog2(NUM_GROUPS),
    localparam int ADDR_W      = IDX_W + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       irq_src,
    output logic [NUM_GROUPS-1:0] cpu_irq,
    input  logic                  svc_req,
    input  logic [GRP_W-1:0]      svc_line,
    output logic                  vec_valid,
    output logic [VEC_W-1:0]      vec_data,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [VEC_W-1:0]      bus_wdata
);

    logic [NSRC-1:0]       flags;
    logic [NSRC-1:0]       enables;
    logic [NUM_GROUPS-1:0] ack;
    logic [NUM_GROUPS-1:0] grp_any;
    logic                  hit;
    logic [IDX_W-1:0]      win_idx;
    logic                  take_hit;
    logic                  lat_hit;
    logic [IDX_W-1:0]      lat_idx;
    logic [VEC_W-1:0]      tbl_rd;
    logic [1:0]            bus_rgn;
    logic [IDX_W-1:0]      bus_idx;
    logic                  vec_wr;

    assign bus_rgn = bus_addr[ADDR_W-1 -: 2];
    assign bus_idx = bus_addr[IDX_W-1:0];
    assign vec_wr  = bus_we && (bus_rgn == RGN_VEC);

    irq_flag_bank #(.NSRC(NSRC), .IDX_W(IDX_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_src (irq_src),
        .clr_en  (take_hit),
        .clr_idx (win_idx),
        .flags   (flags)
    );

    irq_cfg_regs #(
        .NUM_GROUPS (NUM_GROUPS),
        .GROUP_SIZE (GROUP_SIZE),
        .GRP_W      (GRP_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we      (bus_we),
        .bus_rgn     (bus_rgn),
        .bus_grp     (bus_idx[GRP_W-1:0]),
        .en_wdata    (bus_wdata[GROUP_SIZE-1:0]),
        .ack_wdata   (bus_wdata[NUM_GROUPS-1:0]),
        .ack_set     (take_hit),
        .ack_set_grp (svc_line),
        .enables     (enables),
        .ack         (ack)
    );

    irq_vec_table #(.NSRC(NSRC), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (vec_wr),
        .wr_idx  (bus_idx),
        .wr_data (bus_wdata),
        .rd_idx  (lat_idx),
        .rd_data (tbl_rd)
    );

    irq_group_arb #(
        .NUM_GROUPS (NUM_GROUPS),
        .GROUP_SIZE (GROUP_SIZE),
        .GRP_W      (GRP_W),
        .IDX_W      (IDX_W)
    ) u_arb (
        .pend    (flags & enables),
        .sel_grp (svc_line),
        .grp_any (grp_any),
        .hit     (hit),
        .win_idx (win_idx)
    );

    irq_fetch_fsm #(.FETCH_CYCLES(FETCH_CYCLES), .IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .svc_req   (svc_req),
        .hit       (hit),
        .win_idx   (win_idx),
        .take_hit  (take_hit),
        .vec_valid (vec_valid),
        .lat_hit   (lat_hit),
        .lat_idx   (lat_idx)
    );

    assign cpu_irq  = grp_any & ~ack;
    assign vec_data = (vec_valid && lat_hit) ? tbl_rd : '0;

endmodule

// File: rtl/irq_fold_chk.sv
module irq_fold_chk #(
    parameter int NUM_GROUPS   = 12,
    parameter int GROUP_SIZE   = 8,
    parameter int VEC_W        = 32,
    parameter int FETCH_CYCLES = 8,
    localparam int NSRC        = NUM_GROUPS * GROUP_SIZE,
    localparam int GRP_W       = $clog2(NUM_GROUPS),
    localparam int CNT_W       = $clog2(FETCH_CYCLES + 2) + 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  svc_req,
    input logic [GRP_W-1:0]      svc_line,
    input logic [NUM_GROUPS-1:0] cpu_irq,
    input logic                  vec_valid,
    input logic [VEC_W-1:0]      vec_data,
    input logic                  take_hit,
    input logic [NUM_GROUPS-1:0] ack,
    input logic [NSRC-1:0]       flags,
    input logic [NSRC-1:0]       enables
);

    logic             busy_c;
    logic [CNT_W-1:0] since;
    logic [GRP_W-1:0] grp_q;
    logic             acc_c;

    assign acc_c = svc_req && !busy_c;

    // Independent tracking of the fetch window; since counts edges from accept (accept edge = 1)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_c <= 1'b0;
            since  <= '0;
            grp_q  <= '0;
        end else if (acc_c) begin
            busy_c <= 1'b1;
            since  <= CNT_W'(1);
            grp_q  <= svc_line;
        end else if (vec_valid) begin
            busy_c <= 1'b0;
            since  <= '0;
        end else if (busy_c) begin
            since  <= since + 1'b1;
        end
    end

    p_fetch_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (busy_c && since == CNT_W'(FETCH_CYCLES + 1)));

    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    p_quiet_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> (vec_data == '0));

    p_take_acks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_hit && !busy_c) |=> (ack[grp_q] && !cpu_irq[grp_q]));

    p_busy_no_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_c |-> !take_hit);

    p_disabled_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & enables) == '0) |-> (cpu_irq == '0));

    p_acked_group_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack[0]) |-> !cpu_irq[0]);

endmodule

bind irq_fold_ctrl irq_fold_chk #(
    .NUM_GROUPS   (NUM_GROUPS),
    .GROUP_SIZE   (GROUP_SIZE),
    .VEC_W        (VEC_W),
    .FETCH_CYCLES (FETCH_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .svc_req   (svc_req),
    .svc_line  (svc_line),
    .cpu_irq   (cpu_irq),
    .vec_valid (vec_valid),
    .vec_data  (vec_data),
    .take_hit  (take_hit),
    .ack       (ack),
    .flags     (flags),
    .enables   (enables)
);

// File: tb/sim_irq_fold_ctrl.sv
`timescale 1ns/1ps
module sim_irq_fold_ctrl;

    localparam int NG    = 12;
    localparam int GS    = 8;
    localparam int NSRC  = NG * GS;
    localparam int FETCH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NSRC-1:0] irq_src = '0;
    logic [NG-1:0] cpu_irq;
    logic          svc_req = 1'b0;
    logic [3:0]    svc_line = '0;
    logic          vec_valid;
    logic [31:0]   vec_data;
    logic          bus_we = 1'b0;
    logic [8:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit prev_valid = 1'b0;

    logic [31:0] exp_vec_q[$];
    int          exp_cyc_q[$];
    string       exp_tag_q[$];

    always #10 clk = ~clk;  // 50 MHz

    irq_fold_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .cpu_irq(cpu_irq),
        .svc_req(svc_req), .svc_line(svc_line), .vec_valid(vec_valid),
        .vec_data(vec_data), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] vec_of(input int i);
        return 32'h5A00_0000 + 32'(i) * 32'h101;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] rgn, input int idx, input logic [31:0] d);
        bus_we    = 1'b1;
        bus_addr  = {rgn, 7'(idx)};
        bus_wdata = d;
        tick();
        bus_we = 1'b0;
    endtask

    // Driver: pushes the expected vector, its due cycle and its requirement
    task automatic service(input int line, input logic [31:0] exp, input string tag);
        svc_req  = 1'b1;
        svc_line = 4'(line);
        exp_vec_q.push_back(exp);
        exp_cyc_q.push_back(cyc + FETCH + 1);
        exp_tag_q.push_back(tag);
        tick();
        svc_req = 1'b0;
    endtask

    task automatic wait_done();
        repeat (FETCH + 2) tick();
        chk(exp_vec_q.size() == 0, "R4 pending vector never delivered",
            32'(exp_vec_q.size()), 32'd0);
    endtask

    task automatic chk_irq(input logic [NG-1:0] exp, input string req);
        chk(cpu_irq == exp, req, 32'(cpu_irq), 32'(exp));
    endtask

    // Monitor: pops and compares each delivered vector
    always @(negedge clk) begin
        if (rst_n) begin
            if (vec_valid) begin
                chk(!prev_valid, "R4 strobe longer than one cycle", 32'd1, 32'd0);
                if (exp_vec_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected vector strobe", vec_data, 32'd0);
                end else begin
                    logic [31:0] ev;
                    int ec;
                    string et;
                    ev = exp_vec_q.pop_front();
                    ec = exp_cyc_q.pop_front();
                    et = exp_tag_q.pop_front();
                    chk(vec_data == ev, et, vec_data, ev);
                    chk(cyc == ec, "R4 strobe cycle", 32'(cyc), 32'(ec));
                end
            end
            prev_valid <= vec_valid;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        chk_irq('0, "R12 reset cpu_irq");
        chk(vec_valid == 1'b0, "R12 reset vec_valid", 32'(vec_valid), 32'd0);
        chk(vec_data == '0, "R12 reset vec_data", vec_data, 32'd0);
        rst_n = 1'b1;
        tick();

        for (int i = 0; i < NSRC; i++) bus_write(2'd0, i, vec_of(i));

        // R3: flag latches while disabled
        irq_src[3] = 1'b1; tick();
        chk_irq('0, "R3 disabled source silent");
        bus_write(2'd1, 0, 32'hFF);
        chk_irq(12'h001, "R3 enable raises latched flag");
        irq_src[5] = 1'b1; tick();

        // R5/R6/R7
        service(0, vec_of(3), "R5 lowest source wins");
        chk_irq('0, "R6 ack drops output");
        wait_done();
        bus_write(2'd2, 0, 32'h0);
        chk_irq('0, "R7 zero write keeps ack");
        bus_write(2'd2, 0, 32'h1);
        chk_irq(12'h001, "R7 one write clears ack");
        service(0, vec_of(5), "R5 next source");
        wait_done();
        bus_write(2'd2, 0, 32'h1);
        chk_irq('0, "R6 flags cleared by fetch");
        irq_src[3] = 1'b0; irq_src[5] = 1'b0;

        // Line 12 with a disabled lower source, R12 enable layout
        bus_write(2'd1, 11, 32'h80);
        irq_src[90] = 1'b1; irq_src[95] = 1'b1; tick();
        chk_irq(12'h800, "R2 line 12 output");
        service(11, vec_of(95), "R5 disabled source skipped");
        wait_done();
        bus_write(2'd2, 0, 32'h800);
        chk_irq('0, "R3 disabled flag keeps output low");
        bus_write(2'd1, 11, 32'hFF);
        chk_irq(12'h800, "R12 enable byte raises line 12");
        service(11, vec_of(90), "R5 enabled late source");
        wait_done();
        bus_write(2'd2, 0, 32'h800);
        irq_src[90] = 1'b0; irq_src[95] = 1'b0;

        // R1: held request does not re-flag
        bus_write(2'd1, 2, 32'hFF);
        irq_src[20] = 1'b1; tick();
        chk_irq(12'h004, "R1 rising edge flags");
        service(2, vec_of(20), "R1 held source vector");
        wait_done();
        bus_write(2'd2, 0, 32'h4);
        chk_irq('0, "R1 held level does not re-flag");
        irq_src[20] = 1'b0; tick();
        irq_src[20] = 1'b1; tick();
        chk_irq(12'h004, "R1 new edge flags again");
        service(2, vec_of(20), "R1 second vector");
        wait_done();
        bus_write(2'd2, 0, 32'h4);
        irq_src[20] = 1'b0;

        // R10: request during fetch ignored
        irq_src[1] = 1'b1; irq_src[17] = 1'b1; tick();
        service(0, vec_of(1), "R10 first fetch");
        repeat (2) tick();
        svc_req = 1'b1; svc_line = 4'd2; tick(); svc_req = 1'b0;
        wait_done();
        chk_irq(12'h004, "R10 ignored request left flag");
        service(2, vec_of(17), "R10 later fetch");
        wait_done();
        bus_write(2'd2, 0, 32'h5);
        chk_irq('0, "R10 all clear");
        irq_src[1] = 1'b0; irq_src[17] = 1'b0;

        // R11: empty group and out-of-range line
        service(4, 32'h0, "R11 empty group zero vector");
        wait_done();
        bus_write(2'd1, 4, 32'hFF);
        irq_src[33] = 1'b1; tick();
        chk_irq(12'h010, "R11 empty fetch set no ack");
        service(13, 32'h0, "R11 out-of-range line zero vector");
        wait_done();
        chk_irq(12'h010, "R11 out-of-range kept output");
        service(4, vec_of(33), "R11 group 4 vector");
        wait_done();
        bus_write(2'd2, 0, 32'h10);
        irq_src[33] = 1'b0;

        // R8: overwrite during a fetch in flight
        bus_write(2'd1, 5, 32'hFF);
        irq_src[40] = 1'b1; tick();
        service(5, 32'hFEED_0040, "R8 overwrite in flight");
        repeat (2) tick();
        bus_write(2'd0, 40, 32'hFEED_0040);
        wait_done();
        bus_write(2'd2, 0, 32'h20);
        irq_src[40] = 1'b0;

        // R9: rise and fetch-clear in the same cycle
        bus_write(2'd1, 6, 32'hFF);
        irq_src[48] = 1'b1; tick();
        irq_src[48] = 1'b0; tick();
        chk_irq(12'h040, "R9 setup");
        irq_src[48] = 1'b1;
        service(6, vec_of(48), "R9 collision vector");
        wait_done();
        bus_write(2'd2, 0, 32'h40);
        chk_irq(12'h040, "R9 set wins over clear");
        service(6, vec_of(48), "R9 re-fetch");
        wait_done();
        bus_write(2'd2, 0, 32'h40);
        chk_irq('0, "R9 cleared after re-fetch");
        irq_src[48] = 1'b0;

        // R2: several groups at once
        bus_write(2'd1, 1, 32'hFF);
        bus_write(2'd1, 3, 32'hFF);
        irq_src[9] = 1'b1; irq_src[26] = 1'b1; tick();
        chk_irq(12'h00A, "R2 two groups high");
        service(1, vec_of(9), "R2 group 1 vector");
        wait_done();
        chk_irq(12'h008, "R2 other group unaffected");
        service(3, vec_of(26), "R2 group 3 vector");
        wait_done();
        bus_write(2'd2, 0, 32'hA);
        chk_irq('0, "R2 all low");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule